// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous Static Memory

This block is a synthesizable model of a pipelined synchronous static memory whose data bus can switch between reads and writes on consecutive cycles without any idle cycle. Each rising clock edge samples the command: address, operation type, burst control, chip selects and per-lane write enables. The matching data transfer takes place at the second enabled edge after that. Write data is sampled at that edge. Read data is registered at that edge and is driven until the next enabled edge.

A low-active clock enable freezes the whole block. Three chip selects gate the start of new operations, and operations already in flight still complete. A burst control input either loads a new address or continues the current four-beat burst. In linear order the burst steps the two low address bits upward, and in interleaved order it XORs them with the beat count. An asynchronous output-off input masks the data bus drive at any time. The bidirectional data bus is split into an input, an output and an output-enable.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous active-high reset clears every pending operation and any active burst. After reset, dq_oe is low until a read completes.
- R2: When a read is issued at enabled edge E, dq_oe rises and dq_out holds the addressed word just after the second enabled edge after E. Both stay until the next enabled edge.
- R3: A write issued at enabled edge E stores dq_in as sampled at the second enabled edge after E. Reads and writes may be issued on every consecutive cycle with no gap. A read issued one cycle after a write to the same address returns the new data.
- R4: While clk_en_n is high, all other synchronous inputs are ignored. No storage changes, and dq_out and dq_oe keep their values. Operations in flight resume where they stopped once clk_en_n returns low.
- R5: A load cycle (burst_next low) starts an operation only when sel_a_n is low, sel_b is high and sel_c_n is low. If any one of them is inactive, nothing starts, but operations already issued still complete.
- R6: Just after the second enabled edge following a deselect cycle or a write command, dq_oe is low.
- R7: drive_off high forces dq_oe low at once, without waiting for a clock edge. Releasing it restores the registered state.
- R8: A burst's address keeps the upper bits of the load address. The low two bits of beat k (k = 0..3, wrapping modulo 4) are base XOR k when seq_linear was 0 at the load, and (base + k) mod 4 when seq_linear was 1.
- R9: Bit i of lane_wr_n, when low, enables the write of bits [i*LANE_W +: LANE_W]. The lane enables are sampled in the same cycle as the command (or burst beat) they belong to. Lanes that are not enabled keep their old contents.
- R10: burst_next high continues the active burst with the next beat and keeps the burst's read or write type, whatever is_read says. With no active burst (after reset or a deselect), burst_next high starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| is_read | input | 1 | 1 = read, 0 = write, sampled on load cycles |
| burst_next | input | 1 | 0 = load a new address, 1 = continue the burst |
| seq_linear | input | 1 | Burst order on load: 1 linear, 0 interleaved |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| drive_off | input | 1 | Asynchronous output disable, active high |
| dq_in | input | LANES*LANE_W | Write data bus |
| dq_out | output | LANES*LANE_W | Read data bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
If a stage register is wrong, it shows at the ports two enabled edges after the affected command. A lost or duplicated stage moves dq_oe by one cycle, so a gap-free alternating read/write stream catches it on the first read. A wrong burst beat or a wrong lane mask corrupts stored words, which appears on the next read of that location, so every address and every lane mask is written and read back. A clock-enable leak changes dq_out or dq_oe during the stall itself.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic       active;
        op_kind_e   kind;
        logic       linear;
        logic [1:0] beat;
    } burst_st_t;

    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] beat,
                                             input logic       linear);
        return linear ? 2'(base + beat) : (base ^ beat);
    endfunction

    function automatic logic all_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              is_read,
    input  logic              burst_next,
    input  logic              seq_linear,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_kind_e          iss_kind,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LANES-1:0]  iss_be
);

    burst_st_t         burst_q, burst_d;
    logic [ADDR_W-1:0] base_q, base_d;
    op_kind_e          kind_d;
    logic [ADDR_W-1:0] addr_d;
    logic [LANES-1:0]  be_d;
    logic [1:0]        beat_nx;
    logic              selected;

    assign selected = all_selected(sel_a_n, sel_b, sel_c_n);
    assign beat_nx  = 2'(burst_q.beat + 2'd1);

    always_comb begin
        kind_d  = OP_NONE;
        addr_d  = iss_addr;
        be_d    = '0;
        burst_d = burst_q;
        base_d  = base_q;
        if (!burst_next) begin
            if (selected) begin
                kind_d         = is_read ? OP_READ : OP_WRITE;
                addr_d         = addr;
                be_d           = ~lane_wr_n;
                burst_d.active = 1'b1;
                burst_d.kind   = kind_d;
                burst_d.linear = seq_linear;
                burst_d.beat   = 2'd0;
                base_d         = addr;
            end else begin
                burst_d.active = 1'b0;
            end
        end else if (burst_q.active) begin
            kind_d       = burst_q.kind;
            addr_d       = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], beat_nx, burst_q.linear)};
            be_d         = ~lane_wr_n;
            burst_d.beat = beat_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_kind <= OP_NONE;
            iss_addr <= '0;
            iss_be   <= '0;
            burst_q  <= '0;
            base_q   <= '0;
        end else if (!clk_en_n) begin
            iss_kind <= kind_d;
            iss_addr <= addr_d;
            iss_be   <= be_d;
            burst_q  <= burst_d;
            base_q   <= base_d;
        end
    end

    // R5: a load with an inactive select issues nothing
    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_next && !all_selected(sel_a_n, sel_b, sel_c_n)) |=> (iss_kind == OP_NONE));

    // R10: advancing with no burst open issues nothing
    assert_no_orphan_beat_R10: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_next && !burst_q.active) |=> (iss_kind == OP_NONE));

    // R10: a continued beat keeps the type that opened the burst
    assert_beat_keeps_kind_R10: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_next && burst_q.active) |=> (iss_kind == $past(burst_q.kind)));

endmodule

// File: rtl/zbt_stage.sv
module zbt_stage
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  op_kind_e          in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    output op_kind_e          out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LANES-1:0]  out_be
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_kind <= OP_NONE;
            out_addr <= '0;
            out_be   <= '0;
        end else if (!clk_en_n) begin
            out_kind <= in_kind;
            out_addr <= in_addr;
            out_be   <= in_be;
        end
    end

    // R4: a stalled cycle leaves the in-flight operation untouched
    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(out_kind) && $stable(out_addr) && $stable(out_be)));

endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  op_kind_e                ex_kind,
    input  logic [ADDR_W-1:0]       ex_addr,
    input  logic [LANES-1:0]        ex_be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_q,
    output logic                    rvalid_q
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] rd_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst && !clk_en_n && ex_kind == OP_WRITE && ex_be[g]) begin
                cells[ex_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = cells[ex_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (!clk_en_n) begin
            rvalid_q <= (ex_kind == OP_READ);
            if (ex_kind == OP_READ) begin
                rdata_q <= rd_word;
            end
        end
    end

    // R2: an executing read drives the bus after the edge
    assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ex_kind == OP_READ) |=> rvalid_q);

    // R6: an executing write or empty slot releases the bus
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ex_kind != OP_READ) |=> !rvalid_q);

    // R4: stalled cycles keep the output register
    assert_output_hold_R4: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(rdata_q) && $stable(rvalid_q)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    is_read,
    input  logic                    burst_next,
    input  logic                    seq_linear,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    drive_off,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    op_kind_e          s1_kind, s2_kind;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_be, s2_be;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    zbt_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .clk_en_n   (clk_en_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .is_read    (is_read),
        .burst_next (burst_next),
        .seq_linear (seq_linear),
        .lane_wr_n  (lane_wr_n),
        .addr       (addr),
        .iss_kind   (s1_kind),
        .iss_addr   (s1_addr),
        .iss_be     (s1_be)
    );

    zbt_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .in_kind  (s1_kind),
        .in_addr  (s1_addr),
        .in_be    (s1_be),
        .out_kind (s2_kind),
        .out_addr (s2_addr),
        .out_be   (s2_be)
    );

    zbt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .ex_kind  (s2_kind),
        .ex_addr  (s2_addr),
        .ex_be    (s2_be),
        .wdata    (dq_in),
        .rdata_q  (rdata),
        .rvalid_q (rvalid)
    );

    assign dq_out = rdata;
    assign dq_oe  = rvalid & ~drive_off;

    // R2: a read issued now reaches the execute slot after the next enabled edge
    assert_read_reaches_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && s1_kind == OP_READ) |=> (s2_kind == OP_READ));

endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          is_read = 1'b1;
    logic          burst_next = 1'b0;
    logic          seq_linear = 1'b0;
    logic [NL-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic          drive_off = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_zbt_sram (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .is_read(is_read), .burst_next(burst_next),
        .seq_linear(seq_linear), .lane_wr_n(lane_wr_n), .addr(addr),
        .drive_off(drive_off), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Reference state derived from the requirements
    logic [DW-1:0] ref_mem [DEPTH];
    int            m1_k = 0, m2_k = 0;           // 0 none, 1 read, 2 write
    logic [AW-1:0] m1_a = '0, m2_a = '0;
    logic [NL-1:0] m1_be = '0, m2_be = '0;
    logic [DW-1:0] m1_d = '0, m2_d = '0;
    bit            b_act = 1'b0, b_rd = 1'b0, b_lin = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_beat = '0;
    bit            exp_oe = 1'b0;
    logic [DW-1:0] exp_out = '0;

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'(a) * DW'(40503) ^ DW'(s * 7919) ^ {4'(s), 32'h0};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " dq_oe"}, DW'(dq_oe), DW'(exp_oe));
        if (exp_oe) check({tag, " dq_out"}, dq_out, exp_out);
    endtask

    // selc: 0 all selected, 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high
    task automatic step(input string tag, input bit stall, input int selc, input bit adv,
                        input bit rd, input logic [AW-1:0] a, input logic [NL-1:0] bn,
                        input logic [DW-1:0] din, input bit lin);
        int nk;
        logic [AW-1:0] na;
        @(negedge clk);
        clk_en_n   = stall;
        sel_a_n    = (selc == 1);
        sel_b      = (selc != 2);
        sel_c_n    = (selc == 3);
        burst_next = adv;
        is_read    = rd;
        addr       = a;
        lane_wr_n  = bn;
        seq_linear = lin;
        dq_in      = (!stall && m2_k == 2) ? m2_d : ~din;
        @(posedge clk);
        if (!stall) begin
            if (m2_k == 2) begin
                for (int l = 0; l < NL; l++)
                    if (m2_be[l]) ref_mem[m2_a][l*LW +: LW] = m2_d[l*LW +: LW];
            end
            if (m2_k == 1) begin
                exp_oe  = 1'b1;
                exp_out = ref_mem[m2_a];
            end else begin
                exp_oe = 1'b0;
            end
            m2_k = m1_k; m2_a = m1_a; m2_be = m1_be; m2_d = m1_d;
            nk = 0; na = m1_a;
            if (!adv) begin
                if (selc == 0) begin
                    nk = rd ? 1 : 2; na = a;
                    b_act = 1'b1; b_rd = rd; b_lin = lin; b_base = a; b_beat = 2'd0;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_beat = 2'(b_beat + 2'd1);
                nk = b_rd ? 1 : 2;
                na = {b_base[AW-1:2], b_lin ? 2'(b_base[1:0] + b_beat) : (b_base[1:0] ^ b_beat)};
            end
            m1_k = nk; m1_a = na; m1_be = ~bn; m1_d = din;
        end
        #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 2, 1'b0, 1'b1, '0, '1, '0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset dq_oe", DW'(dq_oe), '0);
        // R10: advancing right after reset starts nothing
        step("R10 orphan advance", 1'b0, 0, 1'b1, 1'b1, 6'd3, '1, '0, 1'b0);
        step("R10 orphan advance", 1'b0, 0, 1'b1, 1'b0, 6'd4, '0, '0, 1'b0);
        idle("R1 drain"); idle("R1 drain");

        // R3: clear memory with back-to-back full writes, then R2 read sweep
        for (int a = 0; a < DEPTH; a++)
            step("R3 write sweep", 1'b0, 0, 1'b0, 1'b0, AW'(a), '0, pat(a, 1), 1'b0);
        for (int a = 0; a < DEPTH; a++)
            step("R2 read sweep", 1'b0, 0, 1'b0, 1'b1, AW'(a), '1, '0, 1'b0);
        idle("R6 after reads"); idle("R6 after reads");

        // R3: alternating write/read every cycle, read-after-write same address
        for (int a = 0; a < DEPTH; a++) begin
            step("R3 alt write", 1'b0, 0, 1'b0, 1'b0, AW'(a), '0, pat(a, 2), 1'b0);
            step("R3 alt read", 1'b0, 0, 1'b0, 1'b1, AW'(a), '1, '0, 1'b0);
        end
        for (int a = 0; a < 8; a++) begin
            step("R3 read then write", 1'b0, 0, 1'b0, 1'b1, AW'(a), '1, '0, 1'b0);
            step("R3 read then write", 1'b0, 0, 1'b0, 1'b0, AW'(a), '0, pat(a, 3), 1'b0);
        end
        idle("R6 write release"); idle("R6 write release");

        // R9: every lane mask
        for (int m = 0; m < 16; m++) begin
            step("R9 lane write", 1'b0, 0, 1'b0, 1'b0, AW'(m + 20), NL'(m), pat(m, 9), 1'b0);
            step("R9 lane read", 1'b0, 0, 1'b0, 1'b1, AW'(m + 20), '1, '0, 1'b0);
        end
        idle("R9 drain"); idle("R9 drain");

        // R4: stall with reads and writes in flight and garbage inputs
        for (int s = 1; s <= 4; s++) begin
            step("R4 pre", 1'b0, 0, 1'b0, 1'b1, AW'(s), '1, '0, 1'b0);
            step("R4 pre", 1'b0, 0, 1'b0, 1'b0, AW'(s + 8), '0, pat(s, 4), 1'b0);
            for (int k = 0; k < s; k++)
                step("R4 stall", 1'b1, 0, 1'b0, 1'b0, AW'(s), '0, pat(k, 99), 1'b1);
            step("R4 post", 1'b0, 0, 1'b0, 1'b1, AW'(s + 8), '1, '0, 1'b0);
            step("R4 post", 1'b0, 0, 1'b0, 1'b1, AW'(s), '1, '0, 1'b0);
            idle("R4 drain"); idle("R4 drain");
        end

        // R5 / R6: deselect through each select while transfers are pending
        for (int c = 1; c <= 3; c++) begin
            step("R5 pending write", 1'b0, 0, 1'b0, 1'b0, AW'(40 + c), '0, pat(c, 5), 1'b0);
            step("R5 pending read", 1'b0, 0, 1'b0, 1'b1, AW'(40 + c), '1, '0, 1'b0);
            step("R5 deselect", 1'b0, c, 1'b0, 1'b0, AW'(40 + c), '0, pat(c, 55), 1'b0);
            step("R5 deselect", 1'b0, c, 1'b0, 1'b1, AW'(40 + c), '1, '0, 1'b0);
            step("R6 released", 1'b0, c, 1'b1, 1'b1, AW'(40 + c), '1, '0, 1'b0);
            step("R10 advance after deselect", 1'b0, 0, 1'b1, 1'b0, AW'(40 + c), '0, pat(c, 77), 1'b0);
            step("R5 verify", 1'b0, 0, 1'b0, 1'b1, AW'(40 + c), '1, '0, 1'b0);
            idle("R5 drain"); idle("R5 drain");
        end

        // R8 / R10: bursts in both orders from every start offset
        for (int lin = 0; lin < 2; lin++) begin
            for (int st = 0; st < 4; st++) begin
                step("R8 burst write load", 1'b0, 0, 1'b0, 1'b0, AW'(48 + st), '0, pat(st, 10 + lin), bit'(lin));
                for (int b = 1; b < 4; b++)
                    step("R10 burst write beat", 1'b0, 0, 1'b1, 1'b1, AW'(st), '0, pat(st + b * 4, 10 + lin), 1'b0);
                step("R8 burst read load", 1'b0, 0, 1'b0, 1'b1, AW'(48 + st), '1, '0, bit'(lin));
                for (int b = 1; b < 5; b++)
                    step("R8 burst read beat", 1'b0, 0, 1'b1, 1'b0, AW'(st), '0, '0, 1'b1);
                idle("R8 drain"); idle("R8 drain");
                for (int a = 48; a < 52; a++)
                    step("R8 burst readback", 1'b0, 0, 1'b0, 1'b1, AW'(a), '1, '0, 1'b0);
                idle("R8 drain"); idle("R8 drain");
            end
        end

        // R7: asynchronous output disable
        step("R7 setup", 1'b0, 0, 1'b0, 1'b1, 6'd7, '1, '0, 1'b0);
        idle("R7 setup");
        idle("R7 read out");
        drive_off = 1'b1;
        #1;
        check("R7 forced off", DW'(dq_oe), '0);
        drive_off = 1'b0;
        #1;
        check("R7 restored", DW'(dq_oe), DW'(exp_oe));
        idle("R7 drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule